// File: doc/BRIEF.md
# SMBus Host Controller Register Engine

This block is the software-facing part of an SMBus host controller. A byte-wide register port holds a status byte, a control byte, a command byte, a target address byte, two data bytes and a port into a 32-entry block buffer. Software fills in the address, command and data, then writes control with the start bit set. That write only marks the host as busy. The transaction itself is issued on the next read of status that finds the host busy.

The engine then hands an abstract SMBus master a request that carries the protocol, the direction, the 7-bit target, the command byte, a 16-bit write word and a block length. It holds the request until the master answers with an ack or a nack and any read data. Block payloads move through the buffer. The master fetches write bytes by index and streams read bytes in. On completion the engine updates the data registers and the status flags, and it raises an interrupt line when that is enabled.

Register offsets: 0 status, 2 control, 3 command, 4 address, 5 data0, 6 data1, 7 block port. Offset 1 reads as zero.

Top module: `smb_host_engine`

## Requirements
- R1: After reset every register, the block index and the block buffer are zero, `irq` is low and `txnReq` is low.
- R2: Writing status (offset 0) clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R3: A read of control (offset 2) returns control bits 4:0, with bits 7:5 read as 0. Bits 4:2 are the protocol code: 0 quick, 1 send/receive byte, 2 byte data, 3 word data, 4 process call, 5 block, 6 I2C block. Bit 0 is interrupt enable.
- R4: A control write with bit 6 set sets status bit 0 (busy) and raises no request.
- R5: A status read while busy is set and status bit 2 is clear returns the status with busy still set. `txnReq` goes high in the next cycle and stays high until `rspValid`, and busy is clear from that cycle on.
- R6: A status read while busy and status bit 2 (device error) are both set issues no request, clears busy and leaves device error set.
- R7: A response with `rspAck` high sets status bit 7 (byte done) and bit 1 (interrupt). `irq` is high exactly while status bit 1 and control bit 0 are both set.
- R8: A response with `rspAck` low sets status bit 2 and changes neither data register.
- R9: While the request is held, `txnProt` equals control bits 4:2, `txnRead` equals address bit 0, `txnAddr` equals address bits 7:1, `txnCmd` equals the command register, and `txnWdata` equals {data1, data0}.
- R10: On an acked read, protocols 1 and 2 load data0 from `rspData[7:0]`. Word data reads and every process call load data0 from `rspData[7:0]` and data1 from `rspData[15:8]`.
- R11: A read or write of the block port (offset 7) accesses the entry at the block index and then advances the index. After entry 31 the index wraps to 0.
- R12: `txnLen` equals data0 when data0 is 32 or less, and 32 otherwise.
- R13: Bytes arriving on `rspByte` with `rspByteValid` during a request are stored in entries 0, 1, 2, and so on. `mstByte` shows the buffer entry selected by `mstIdx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 3 | Register byte offset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (side effects at the clock edge) |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, combinational from `regSel` |
| irq | output | 1 | Interrupt |
| txnReq | output | 1 | Transaction request, held until response |
| txnProt | output | 3 | Protocol code |
| txnRead | output | 1 | 1 = read direction |
| txnAddr | output | 7 | Target address |
| txnCmd | output | 8 | Command byte |
| txnWdata | output | 16 | Write word {data1, data0} |
| txnLen | output | 6 | Block length, clamped to 32 |
| mstIdx | input | 5 | Buffer index requested by the master |
| mstByte | output | 8 | Buffer entry at `mstIdx` |
| rspValid | input | 1 | Response strobe, one cycle |
| rspAck | input | 1 | 1 = acked, 0 = nack or failure |
| rspData | input | 16 | Read word or byte |
| rspByteValid | input | 1 | Block read byte strobe |
| rspByte | input | 8 | Block read byte |

## Verification
The assertions assume that the register port never reads and writes in the same cycle. They also assume that software neither writes control with start nor touches the block port while a request is outstanding. Finally, they assume the master raises `rspValid` only while `txnReq` is high, and no earlier than the cycle after the request rises. The bench keeps to these rules by driving every register access through single-operation tasks. Its master model answers only after it sees `txnReq`, and each random transaction is run to completion before the next register access.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam int ST_BUSY   = 0;
  localparam int ST_INTR   = 1;
  localparam int ST_DEVERR = 2;
  localparam int ST_DONE   = 7;
  localparam int CT_IE     = 0;
  localparam int CT_START  = 6;

  localparam logic [2:0] SEL_STAT = 3'd0;
  localparam logic [2:0] SEL_CTL  = 3'd2;
  localparam logic [2:0] SEL_CMD  = 3'd3;
  localparam logic [2:0] SEL_ADDR = 3'd4;
  localparam logic [2:0] SEL_D0   = 3'd5;
  localparam logic [2:0] SEL_D1   = 3'd6;
  localparam logic [2:0] SEL_BLK  = 3'd7;

  localparam logic [2:0] PR_BYTE  = 3'd1;
  localparam logic [2:0] PR_BDATA = 3'd2;
  localparam logic [2:0] PR_WORD  = 3'd3;
  localparam logic [2:0] PR_PCALL = 3'd4;

  typedef struct packed {
    logic launch;
    logic clrBusy;
    logic doneOk;
    logic doneErr;
    logic pending;
  } strobe_t;
endpackage

// File: rtl/smbh_ctrl.sv
module smbh_ctrl
  import smbh_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    statusRead,
  input  logic    busyBit,
  input  logic    devErrBit,
  input  logic    rspValid,
  input  logic    rspAck,
  output strobe_t stb,
  output logic    txnReq
);
  typedef enum logic {IDLE, WAIT} state_t;
  state_t state, stateNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    stb.pending = (state == WAIT);
    if (state == IDLE) begin
      if (statusRead && busyBit) begin
        if (devErrBit) begin
          stb.clrBusy = 1'b1;
        end else begin
          stb.launch = 1'b1;
          stateNext  = WAIT;
        end
      end
    end else if (rspValid) begin
      stb.doneOk  = rspAck;
      stb.doneErr = !rspAck;
      stateNext   = IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= IDLE;
    else       state <= stateNext;
  end

  assign txnReq = (state == WAIT);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txnReq && !rspValid) |=> txnReq);
  // R5
  req_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && busyBit && !devErrBit && !txnReq) |=> txnReq);
  // R6
  no_req_on_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && busyBit && devErrBit && !txnReq) |=> !txnReq);
endmodule

// File: rtl/smbh_dpath.sv
module smbh_dpath
  import smbh_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  localparam int IDX_W = $clog2(BUF_DEPTH),
  localparam int LEN_W = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [2:0]       regSel,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  output logic             busyBit,
  output logic             devErrBit,
  output logic             irq,
  output logic [2:0]       txnProt,
  output logic             txnRead,
  output logic [6:0]       txnAddr,
  output logic [7:0]       txnCmd,
  output logic [15:0]      txnWdata,
  output logic [LEN_W-1:0] txnLen,
  input  logic [IDX_W-1:0] mstIdx,
  output logic [7:0]       mstByte,
  input  logic [15:0]      rspData,
  input  logic             rspByteValid,
  input  logic [7:0]       rspByte
);
  localparam logic [7:0] DEPTH8 = 8'(BUF_DEPTH);

  logic [7:0] statReg, cmdReg, addrReg, d0Reg, d1Reg, statNext;
  logic [4:0] ctlReg;
  logic [IDX_W-1:0] blkIdx, fillIdx;
  logic [7:0] blkMem [BUF_DEPTH];

  logic wrStat, wrCtl, blkAccess, fillWr;
  assign wrStat    = regWr && (regSel == SEL_STAT);
  assign wrCtl     = regWr && (regSel == SEL_CTL);
  assign blkAccess = (regWr || regRd) && (regSel == SEL_BLK);
  assign fillWr    = stb.pending && rspByteValid;

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] i);
    if (i == IDX_W'(BUF_DEPTH - 1)) stepIdx = '0;
    else                            stepIdx = i + 1'b1;
  endfunction

  always_comb begin
    unique case (regSel)
      SEL_STAT: regRdata = statReg;
      SEL_CTL:  regRdata = {3'b000, ctlReg};
      SEL_CMD:  regRdata = cmdReg;
      SEL_ADDR: regRdata = addrReg;
      SEL_D0:   regRdata = d0Reg;
      SEL_D1:   regRdata = d1Reg;
      SEL_BLK:  regRdata = blkMem[blkIdx];
      default:  regRdata = 8'h00;
    endcase
  end

  always_comb begin
    statNext = statReg & ~(wrStat ? regWdata : 8'h00);
    if (wrCtl && regWdata[CT_START]) statNext[ST_BUSY] = 1'b1;
    if (stb.launch || stb.clrBusy)   statNext[ST_BUSY] = 1'b0;
    if (stb.doneOk) begin
      statNext[ST_DONE] = 1'b1;
      statNext[ST_INTR] = 1'b1;
    end
    if (stb.doneErr) statNext[ST_DEVERR] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReg <= '0; ctlReg <= '0; cmdReg <= '0; addrReg <= '0;
      d0Reg <= '0; d1Reg <= '0; blkIdx <= '0; fillIdx <= '0;
    end else begin
      statReg <= statNext;
      if (wrCtl) ctlReg <= regWdata[4:0];
      if (regWr && regSel == SEL_CMD)  cmdReg  <= regWdata;
      if (regWr && regSel == SEL_ADDR) addrReg <= regWdata;
      if (regWr && regSel == SEL_D0)   d0Reg   <= regWdata;
      if (regWr && regSel == SEL_D1)   d1Reg   <= regWdata;
      if (blkAccess) blkIdx <= stepIdx(blkIdx);
      if (stb.launch)   fillIdx <= '0;
      else if (fillWr)  fillIdx <= stepIdx(fillIdx);
      if (stb.doneOk) begin
        if (txnProt == PR_PCALL || (txnProt == PR_WORD && txnRead)) begin
          d0Reg <= rspData[7:0];
          d1Reg <= rspData[15:8];
        end else if ((txnProt == PR_BYTE || txnProt == PR_BDATA) && txnRead) begin
          d0Reg <= rspData[7:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_DEPTH; i++) blkMem[i] <= '0;
    end else if (fillWr) begin
      blkMem[fillIdx] <= rspByte;
    end else if (regWr && regSel == SEL_BLK) begin
      blkMem[blkIdx] <= regWdata;
    end
  end

  assign busyBit   = statReg[ST_BUSY];
  assign devErrBit = statReg[ST_DEVERR];
  assign irq       = statReg[ST_INTR] && ctlReg[CT_IE];
  assign txnProt   = ctlReg[4:2];
  assign txnRead   = addrReg[0];
  assign txnAddr   = addrReg[7:1];
  assign txnCmd    = cmdReg;
  assign txnWdata  = {d1Reg, d0Reg};
  assign txnLen    = (d0Reg > DEPTH8) ? LEN_W'(BUF_DEPTH) : d0Reg[LEN_W-1:0];
  assign mstByte   = blkMem[mstIdx];

  // R2
  w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && !stb.doneOk && !stb.doneErr) |=> ((statReg & $past(regWdata)) == 8'h00));
  // R5
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.launch && !wrCtl) |=> !statReg[ST_BUSY]);
  // R7
  done_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.doneOk |=> (statReg[ST_DONE] && statReg[ST_INTR]));
  // R8
  err_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.doneErr |=> (statReg[ST_DEVERR] && $stable(d0Reg) && $stable(d1Reg)));
  // R11
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blkAccess && blkIdx == IDX_W'(BUF_DEPTH - 1)) |=> (blkIdx == '0));
endmodule

// File: rtl/smb_host_engine.sv
module smb_host_engine
  import smbh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regSel,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  output logic        irq,
  output logic        txnReq,
  output logic [2:0]  txnProt,
  output logic        txnRead,
  output logic [6:0]  txnAddr,
  output logic [7:0]  txnCmd,
  output logic [15:0] txnWdata,
  output logic [5:0]  txnLen,
  input  logic [4:0]  mstIdx,
  output logic [7:0]  mstByte,
  input  logic        rspValid,
  input  logic        rspAck,
  input  logic [15:0] rspData,
  input  logic        rspByteValid,
  input  logic [7:0]  rspByte
);
  strobe_t stb;
  logic busyBit, devErrBit, statusRead;

  assign statusRead = regRd && (regSel == SEL_STAT);

  smbh_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .statusRead(statusRead), .busyBit(busyBit),
    .devErrBit(devErrBit), .rspValid(rspValid), .rspAck(rspAck),
    .stb(stb), .txnReq(txnReq)
  );

  smbh_dpath #(.BUF_DEPTH(32)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .regSel(regSel), .regWr(regWr),
    .regRd(regRd), .regWdata(regWdata), .regRdata(regRdata),
    .busyBit(busyBit), .devErrBit(devErrBit), .irq(irq),
    .txnProt(txnProt), .txnRead(txnRead), .txnAddr(txnAddr),
    .txnCmd(txnCmd), .txnWdata(txnWdata), .txnLen(txnLen),
    .mstIdx(mstIdx), .mstByte(mstByte), .rspData(rspData),
    .rspByteValid(rspByteValid), .rspByte(rspByte)
  );
endmodule

// File: tb/sim_smb_host_engine.sv
module sim_smb_host_engine;
  logic clk = 0, rstN = 0;
  logic [2:0] regSel = 0;
  logic regWr = 0, regRd = 0;
  logic [7:0] regWdata = 0, regRdata;
  logic irq, txnReq, txnRead;
  logic [2:0] txnProt;
  logic [6:0] txnAddr;
  logic [7:0] txnCmd, mstByte;
  logic [15:0] txnWdata;
  logic [5:0] txnLen;
  logic [4:0] mstIdx = 0;
  logic rspValid = 0, rspAck = 0, rspByteValid = 0;
  logic [15:0] rspData = 0;
  logic [7:0] rspByte = 0;

  int nChk = 0, nBad = 0;
  logic [7:0] model [32];
  int expIdx = 0;

  always #4 clk = ~clk;

  smb_host_engine u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk); regSel = sel; regWdata = d; regWr = 1;
    @(negedge clk); regWr = 0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [7:0] d);
    @(negedge clk); regSel = sel; regRd = 1; #1 d = regRdata;
    @(negedge clk); regRd = 0;
  endtask

  task automatic respond(input logic ack, input logic [15:0] data);
    rspValid = 1; rspAck = ack; rspData = data;
    @(negedge clk); rspValid = 0;
  endtask

  function automatic logic [15:0] expData(input logic [2:0] p, input logic r,
      input logic ack, input logic [15:0] rsp, input logic [15:0] old);
    if (!ack) return old;
    if (p == 4 || (p == 3 && r)) return rsp;
    if ((p == 1 || p == 2) && r) return {old[15:8], rsp[7:0]};
    return old;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 txnReq", txnReq, 0);
    for (int s = 0; s < 7; s++) begin
      if (s == 1) continue;
      rd(3'(s), v); check("R1 reg", v, 0);
    end
    check("R1 mstByte", mstByte, 0);

    // R3 control mask, R4 no start
    wr(2, 8'hBF); rd(2, v); check("R3 ctl read", v, 8'h1F);
    rd(0, v); check("R4 no busy without start", v, 0);

    // R4 start sets busy only; word write
    wr(4, 8'hA4); wr(3, 8'h5C); wr(5, 8'h34); wr(6, 8'h12);
    wr(2, 8'h40 | (3 << 2) | 1);
    repeat (3) @(negedge clk);
    check("R4 no request before status read", txnReq, 0);
    // R5 status read launches
    rd(0, v); check("R5 read shows busy", v, 8'h01);
    check("R5 txnReq", txnReq, 1);
    check("R9 prot", txnProt, 3);
    check("R9 read", txnRead, 0);
    check("R9 addr", txnAddr, 8'hA4 >> 1);
    check("R9 cmd", txnCmd, 8'h5C);
    check("R9 wdata", txnWdata, 16'h1234);
    @(negedge clk); check("R5 held", txnReq, 1);
    respond(1, 16'hFFFF);
    check("R5 drops after response", txnReq, 0);
    rd(0, v); check("R7 ok flags", v, 8'h82);
    check("R7 irq enabled", irq, 1);
    rd(5, v); check("R10 write leaves data0", v, 8'h34);
    // R2 w1c
    wr(0, 8'h02); rd(0, v); check("R2 clear bit1 only", v, 8'h80);
    check("R7 irq follows status", irq, 0);
    wr(0, 8'h80); rd(0, v); check("R2 clear bit7", v, 0);

    // R10 word read
    wr(4, 8'h51); wr(2, 8'h40 | (3 << 2));
    rd(0, v);
    respond(1, 16'hBEEF);
    rd(5, v); check("R10 word low", v, 8'hEF);
    rd(6, v); check("R10 word high", v, 8'hBE);
    check("R7 irq disabled", irq, 0);
    wr(0, 8'hFF);

    // R8 nack, then R6 blocked launch
    wr(2, 8'h40 | (2 << 2)); rd(0, v);
    respond(0, 16'h0077);
    rd(0, v); check("R8 dev err", v, 8'h04);
    rd(5, v); check("R8 data0 kept", v, 8'hEF);
    wr(2, 8'h40 | (2 << 2));
    rd(0, v); check("R6 read shows busy+err", v, 8'h05);
    check("R6 no request", txnReq, 0);
    rd(0, v); check("R6 busy cleared, err kept", v, 8'h04);
    wr(0, 8'hFF);

    // R11 block port write/read with wrap
    for (int i = 0; i < 33; i++) begin
      v = 8'(i * 7 + 3);
      wr(7, v); model[expIdx] = v; expIdx = (expIdx + 1) % 32;
    end
    for (int i = 0; i < 32; i++) begin
      logic [7:0] got;
      rd(7, got);
      check("R11 block readback", got, model[expIdx]);
      expIdx = (expIdx + 1) % 32;
    end
    // R13 master sees buffer by index
    @(negedge clk); mstIdx = 5; #1 check("R13 mstByte", mstByte, model[5]);
    mstIdx = 31; #1 check("R13 mstByte 31", mstByte, model[31]);

    // R12 clamp
    wr(5, 8'd40); #1 check("R12 clamp", txnLen, 32);
    wr(5, 8'd32); #1 check("R12 edge", txnLen, 32);
    wr(5, 8'd5);  #1 check("R12 pass", txnLen, 5);

    // R13 block read fill
    wr(4, 8'h21); wr(2, 8'h40 | (6 << 2)); rd(0, v);
    for (int i = 0; i < 4; i++) begin
      rspByteValid = 1; rspByte = 8'hC0 + 8'(i); model[i] = rspByte;
      @(negedge clk);
    end
    rspByteValid = 0;
    respond(1, 16'h0);
    while (expIdx != 0) begin rd(7, v); expIdx = (expIdx + 1) % 32; end
    for (int i = 0; i < 4; i++) begin
      rd(7, v); check("R13 filled entry", v, model[i]); expIdx++;
    end
    wr(0, 8'hFF);

    // random byte/word/pcall transactions
    for (int k = 0; k < 24; k++) begin
      logic [2:0] p; logic r, ack; logic [7:0] c, a, d0, d1;
      logic [15:0] rsp, e;
      p = 3'(1 + ($urandom % 4)); a = 8'($urandom); r = a[0];
      c = 8'($urandom); d0 = 8'($urandom); d1 = 8'($urandom);
      ack = ($urandom % 4) != 0; rsp = 16'($urandom);
      wr(4, a); wr(3, c); wr(5, d0); wr(6, d1); wr(2, 8'h40 | {3'b0, p, 2'b01});
      rd(0, v); check("R5 random busy", v, 1);
      check("R9 random prot", txnProt, p);
      check("R9 random addr", {txnAddr, txnRead}, a);
      check("R9 random cmd", txnCmd, c);
      check("R9 random wdata", txnWdata, {d1, d0});
      respond(ack, rsp);
      e = expData(p, r, ack, rsp, {d1, d0});
      rd(0, v); check(ack ? "R7 random status" : "R8 random status", v, ack ? 8'h82 : 8'h04);
      check("R7 random irq", irq, ack);
      rd(5, v); check("R10 random data0", v, e[7:0]);
      rd(6, v); check("R10 random data1", v, e[15:8]);
      wr(0, 8'hFF);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule